// File: doc/BRIEF.md
# Warp Load Coalescer with Sector Accounting

This block takes one warp-wide load request and turns it into the fewest memory transactions that serve it. The request has 32 lanes. Each lane carries a byte address, an active bit, and reads one aligned 4-byte word. Active lanes that fall in the same 128-byte line are merged into one transaction. That transaction names the line and carries a 4-bit mask of the 32-byte sectors it must fetch. Transactions leave the block one per cycle, back to back.

When the last transaction of a request has left, the block raises a one-cycle completion strobe. With that strobe it reports three values for the request: the number of sectors fetched, the bytes those sectors move, and the bytes the lanes actually asked for. Software-visible efficiency counters or a profiler can then compute sector efficiency as useful bytes over moved bytes.

The block accepts a new request only when the previous one has drained completely. It takes no other flow control on its outputs.

Top module: `warpCoalescer`

## Requirements
- R1: After reset, `reqReady` is 1 and `txnValid` and `doneValid` are 0.
- R2: A request is taken only on a cycle with `reqValid` and `reqReady` both high. From that cycle until the cycle after `doneValid`, `reqReady` stays low, and any change on the request inputs has no effect on the transactions or counts produced.
- R3: Each transaction gives the line number as address bits [31:7] on `txnLine`. Bit k of `txnMask` is set exactly when some active lane of the request has address bits [6:5] equal to k in that line.
- R4: A request with active lanes emits exactly one transaction per distinct line touched. The transactions come on consecutive cycles, the first in the cycle right after acceptance, and `doneValid` rises in the cycle after the last one.
- R5: Transactions appear in ascending order of the lowest-numbered active lane that touches each line.
- R6: Lanes whose active bit is 0 add no line, no sector and no useful bytes, whatever their address.
- R7: A request with no active lanes emits no transaction, and `doneValid` is high in the cycle right after acceptance.
- R8: With `doneValid`, `doneSectors` equals the total number of set mask bits over the request's transactions, and `doneMoved` equals 32 times that number.
- R9: With `doneValid`, `doneUseful` equals 4 times the number of distinct word addresses (bits [31:2]) among the active lanes, so repeated addresses count once.
- R10: 32 active lanes that read consecutive words from a line boundary produce one transaction with mask 4'b1111, 128 bytes moved and 128 useful.
- R11: 32 active lanes that each fall in a different line produce 32 single-sector transactions, 1024 bytes moved and 128 useful.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | A request is present |
| reqReady | output | 1 | Block is idle and takes a request |
| reqAddr | input | 1024 | Lane byte addresses, lane i at bits [32*i+31 : 32*i] |
| reqActive | input | 32 | Per-lane active bits, lane i at bit i |
| txnValid | output | 1 | A transaction is presented this cycle |
| txnLine | output | 25 | Line number of the transaction (address bits [31:7]) |
| txnMask | output | 4 | Sector mask, bit k = sector k of the line |
| doneValid | output | 1 | One-cycle strobe: request fully drained |
| doneSectors | output | 6 | Sectors fetched for the request |
| doneMoved | output | 11 | Bytes moved (32 per sector) |
| doneUseful | output | 8 | Distinct useful bytes requested |

## Verification
The hardest case to reach from the ports is a busy block that sees a new request with different addresses. The correct response is to drain the first request untouched and then take the second one right after the completion strobe. The stimulus keeps `reqValid` high and swaps the lane addresses one cycle into a 32-transaction strided request. It then checks that every transaction and count belongs to the first request, and that the second is accepted in the first ready cycle. Ordering by first-touching lane only shows up when lane order and line order differ, so one scenario maps ascending lanes onto descending lines. Pseudo-random requests over a narrow eight-line window then mix partial masks, duplicate words and inactive lanes.

// File: rtl/warpCoalescePkg.sv
package warpCoalescePkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_EMIT = 2'd1,
    ST_DONE = 2'd2
  } coalState_t;

  // strobes from the control FSM to the datapath
  typedef struct packed {
    logic load;   // capture a new request
    logic step;   // retire the current line group
  } dpStrobe_t;

endpackage

// File: rtl/warpLeaderPick.sv
// Lowest-index set bit of a request vector.
module warpLeaderPick #(
  parameter int N = 32,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx,
  output logic             any
);

  always_comb begin
    idx = '0;
    any = 1'b0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) begin
        idx = IDX_W'(i);
        any = 1'b1;
      end
    end
  end

endmodule

// File: rtl/warpDatapath.sv
module warpDatapath
  import warpCoalescePkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4,
  localparam int LINE_SHIFT   = $clog2(LINE_BYTES),
  localparam int SECTOR_SHIFT = $clog2(SECTOR_BYTES),
  localparam int WORD_SHIFT   = $clog2(WORD_BYTES),
  localparam int SECTORS      = LINE_BYTES / SECTOR_BYTES,
  localparam int LINE_W       = ADDR_W - LINE_SHIFT,
  localparam int SEC_CNT_W    = $clog2(LANES + 1),
  localparam int USEFUL_W     = $clog2(LANES * WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  dpStrobe_t               strobe,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqActive,
  output logic                    pendingAny,
  output logic                    lastGroup,
  output logic [LINE_W-1:0]       txnLine,
  output logic [SECTORS-1:0]      txnMask,
  output logic [SEC_CNT_W-1:0]    sectorTotal,
  output logic [USEFUL_W-1:0]     usefulTotal
);

  localparam int SEL_W   = LINE_SHIFT - SECTOR_SHIFT;
  localparam int WORD_W  = ADDR_W - WORD_SHIFT;
  localparam int IDX_W   = (LANES > 1) ? $clog2(LANES) : 1;
  localparam int GRPS_W  = $clog2(SECTORS + 1);
  localparam int GRPU_W  = $clog2(LANES * WORD_BYTES + 1);

  logic [ADDR_W-1:0]    addrQ [LANES];
  logic [LANES-1:0]     activeQ;
  logic [LANES-1:0]     pendingQ;
  logic [SEC_CNT_W-1:0] sectorAcc;
  logic [USEFUL_W-1:0]  usefulAcc;

  logic [LINE_W-1:0]    lineOf   [LANES];
  logic [WORD_W-1:0]    wordOf   [LANES];
  logic [SEL_W-1:0]     sectorOf [LANES];
  logic [LANES-1:0]     firstOfWord;
  logic [LANES-1:0]     groupHit;
  logic [IDX_W-1:0]     leadIdx;
  logic                 leadAny;
  logic [LINE_W-1:0]    leadLine;
  logic [SECTORS-1:0]   groupMask;
  logic [GRPS_W-1:0]    groupSectors;
  logic [GRPU_W-1:0]    groupUseful;

  // address fields per lane
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      lineOf[i]   = addrQ[i][ADDR_W-1:LINE_SHIFT];
      wordOf[i]   = addrQ[i][ADDR_W-1:WORD_SHIFT];
      sectorOf[i] = addrQ[i][LINE_SHIFT-1:SECTOR_SHIFT];
    end
  end

  // an active lane is the first owner of its word if no lower active lane shares it
  always_comb begin
    for (int i = 0; i < LANES; i++) begin
      firstOfWord[i] = activeQ[i];
      for (int j = 0; j < LANES; j++) begin
        if (j < i && activeQ[j] && wordOf[j] == wordOf[i]) begin
          firstOfWord[i] = 1'b0;
        end
      end
    end
  end

  warpLeaderPick #(.N(LANES)) leaderPick (
    .req (pendingQ),
    .idx (leadIdx),
    .any (leadAny)
  );

  assign leadLine = lineOf[leadIdx];

  // all pending lanes sharing the leader's line form this cycle's group
  always_comb begin
    groupMask = '0;
    for (int i = 0; i < LANES; i++) begin
      groupHit[i] = pendingQ[i] && (lineOf[i] == leadLine);
      if (groupHit[i]) begin
        groupMask[sectorOf[i]] = 1'b1;
      end
    end
  end

  always_comb begin
    groupSectors = '0;
    for (int k = 0; k < SECTORS; k++) begin
      groupSectors = groupSectors + GRPS_W'(groupMask[k]);
    end
    groupUseful = '0;
    for (int i = 0; i < LANES; i++) begin
      if (groupHit[i] && firstOfWord[i]) begin
        groupUseful = groupUseful + GRPU_W'(WORD_BYTES);
      end
    end
  end

  // address capture: no reset needed, qualified by activeQ
  always_ff @(posedge clk) begin
    if (strobe.load) begin
      for (int i = 0; i < LANES; i++) begin
        addrQ[i] <= reqAddr[i*ADDR_W +: ADDR_W];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ   <= '0;
      pendingQ  <= '0;
      sectorAcc <= '0;
      usefulAcc <= '0;
    end else if (strobe.load) begin
      activeQ   <= reqActive;
      pendingQ  <= reqActive;
      sectorAcc <= '0;
      usefulAcc <= '0;
    end else if (strobe.step) begin
      pendingQ  <= pendingQ & ~groupHit;
      sectorAcc <= sectorAcc + SEC_CNT_W'(groupSectors);
      usefulAcc <= usefulAcc + USEFUL_W'(groupUseful);
    end
  end

  assign pendingAny  = leadAny;
  assign lastGroup   = ((pendingQ & ~groupHit) == '0);
  assign txnLine     = leadLine;
  assign txnMask     = groupMask;
  assign sectorTotal = sectorAcc;
  assign usefulTotal = usefulAcc;

  // every retired group removes at least one lane
  AST_STEP_DRAINS: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.step && pendingAny) |=> ($countones(pendingQ) < $countones($past(pendingQ)))); // R4

  // a group with a leader always needs at least one sector
  AST_GROUP_HAS_SECTOR: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> (groupMask != '0)); // R3

  // a group never carries more sectors than lanes
  AST_GROUP_SECTOR_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    pendingAny |-> ($countones(groupMask) <= $countones(groupHit))); // R8

endmodule

// File: rtl/warpControl.sv
module warpControl
  import warpCoalescePkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  input  logic      reqAnyActive,
  input  logic      pendingAny,
  input  logic      lastGroup,
  output dpStrobe_t strobe,
  output logic      reqReady,
  output logic      txnValid,
  output logic      doneValid
);

  coalState_t stateQ, stateD;

  always_comb begin
    stateD      = stateQ;
    strobe      = '0;
    reqReady    = 1'b0;
    txnValid    = 1'b0;
    doneValid   = 1'b0;
    unique case (stateQ)
      ST_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          strobe.load = 1'b1;
          stateD      = reqAnyActive ? ST_EMIT : ST_DONE;
        end
      end
      ST_EMIT: begin
        txnValid    = 1'b1;
        strobe.step = 1'b1;
        if (lastGroup) begin
          stateD = ST_DONE;
        end
      end
      ST_DONE: begin
        doneValid = 1'b1;
        stateD    = ST_IDLE;
      end
      default: begin
        stateD = ST_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
    end else begin
      stateQ <= stateD;
    end
  end

  // the datapath must hold a pending lane whenever a transaction is shown
  AST_EMIT_HAS_LANE: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> pendingAny); // R4

  // after acceptance the block stays busy for at least one cycle
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady); // R2

endmodule

// File: rtl/warpCoalescer.sv
module warpCoalescer
  import warpCoalescePkg::*;
#(
  parameter int LANES        = 32,
  parameter int ADDR_W       = 32,
  parameter int LINE_BYTES   = 128,
  parameter int SECTOR_BYTES = 32,
  parameter int WORD_BYTES   = 4,
  localparam int LINE_SHIFT   = $clog2(LINE_BYTES),
  localparam int SECTOR_SHIFT = $clog2(SECTOR_BYTES),
  localparam int SECTORS      = LINE_BYTES / SECTOR_BYTES,
  localparam int LINE_W       = ADDR_W - LINE_SHIFT,
  localparam int SEC_CNT_W    = $clog2(LANES + 1),
  localparam int MOVED_W      = $clog2(LANES * SECTOR_BYTES + 1),
  localparam int USEFUL_W     = $clog2(LANES * WORD_BYTES + 1)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  output logic                    reqReady,
  input  logic [LANES*ADDR_W-1:0] reqAddr,
  input  logic [LANES-1:0]        reqActive,
  output logic                    txnValid,
  output logic [LINE_W-1:0]       txnLine,
  output logic [SECTORS-1:0]      txnMask,
  output logic                    doneValid,
  output logic [SEC_CNT_W-1:0]    doneSectors,
  output logic [MOVED_W-1:0]      doneMoved,
  output logic [USEFUL_W-1:0]     doneUseful
);

  dpStrobe_t strobe;
  logic      pendingAny;
  logic      lastGroup;

  warpControl control (
    .clk          (clk),
    .rstN         (rstN),
    .reqValid     (reqValid),
    .reqAnyActive (|reqActive),
    .pendingAny   (pendingAny),
    .lastGroup    (lastGroup),
    .strobe       (strobe),
    .reqReady     (reqReady),
    .txnValid     (txnValid),
    .doneValid    (doneValid)
  );

  warpDatapath #(
    .LANES        (LANES),
    .ADDR_W       (ADDR_W),
    .LINE_BYTES   (LINE_BYTES),
    .SECTOR_BYTES (SECTOR_BYTES),
    .WORD_BYTES   (WORD_BYTES)
  ) datapath (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqAddr     (reqAddr),
    .reqActive   (reqActive),
    .pendingAny  (pendingAny),
    .lastGroup   (lastGroup),
    .txnLine     (txnLine),
    .txnMask     (txnMask),
    .sectorTotal (doneSectors),
    .usefulTotal (doneUseful)
  );

  assign doneMoved = MOVED_W'(doneSectors) << SECTOR_SHIFT;

  // completion returns the block to idle on the next cycle
  AST_DONE_THEN_READY: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> reqReady); // R2

  // no transaction while the input side is open
  AST_TXN_NOT_READY: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady); // R2

  // useful bytes can never exceed moved bytes
  AST_USEFUL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (MOVED_W'(doneUseful) <= doneMoved)); // R9

  // an all-inactive request finishes in the next cycle without a transaction
  AST_EMPTY_DONE: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqActive == '0)) |=> (doneValid && !txnValid)); // R7

  // a request with lanes always starts emitting in the next cycle
  AST_FIRST_TXN: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqActive != '0)) |=> txnValid); // R4

endmodule

// File: tb/warpCoalescer_test.sv
module warpCoalescer_test;

  localparam int LANES  = 32;
  localparam int ADDR_W = 32;
  localparam int LINE_W = 25;

  logic                    clk = 1'b0;
  logic                    rstN = 1'b0;
  logic                    reqValid = 1'b0;
  logic                    reqReady;
  logic [LANES*ADDR_W-1:0] reqAddr = '0;
  logic [LANES-1:0]        reqActive = '0;
  logic                    txnValid;
  logic [LINE_W-1:0]       txnLine;
  logic [3:0]              txnMask;
  logic                    doneValid;
  logic [5:0]              doneSectors;
  logic [10:0]             doneMoved;
  logic [7:0]              doneUseful;

  warpCoalescer uut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqActive(reqActive), .txnValid(txnValid),
    .txnLine(txnLine), .txnMask(txnMask), .doneValid(doneValid),
    .doneSectors(doneSectors), .doneMoved(doneMoved), .doneUseful(doneUseful)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  bit summaryDone = 1'b0;

  logic [31:0] laneAddr [LANES];
  logic [31:0] laneAct;

  // expected
  logic [LINE_W-1:0] expLine [LANES];
  logic [3:0]        expMask [LANES];
  int expCount, expSectors, expUseful;

  // observed
  logic [LINE_W-1:0] obsLine [64];
  logic [3:0]        obsMask [64];
  int obsCount, obsSectors, obsMoved, obsUseful, obsGap, obsFirstCycle, obsDoneCycle;
  bit obsDone;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    if (!summaryDone) begin
      summaryDone = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  // reference from the requirements
  task automatic buildExpected();
    logic [29:0] words [LANES];
    int nWords;
    expCount = 0; expSectors = 0; nWords = 0;
    for (int i = 0; i < LANES; i++) begin
      if (laneAct[i]) begin
        logic [LINE_W-1:0] ln;
        int pos;
        bit seen;
        ln  = laneAddr[i][31:7];
        pos = -1;
        for (int t = 0; t < expCount; t++) if (expLine[t] == ln) pos = t;
        if (pos < 0) begin
          expLine[expCount] = ln;
          expMask[expCount] = 4'b0000;
          pos = expCount;
          expCount++;
        end
        expMask[pos][laneAddr[i][6:5]] = 1'b1;
        seen = 1'b0;
        for (int w = 0; w < nWords; w++) if (words[w] == laneAddr[i][31:2]) seen = 1'b1;
        if (!seen) begin
          words[nWords] = laneAddr[i][31:2];
          nWords++;
        end
      end
    end
    for (int t = 0; t < expCount; t++)
      for (int k = 0; k < 4; k++) expSectors += int'(expMask[t][k]);
    expUseful = 4 * nWords;
  endtask

  task automatic driveInputs();
    for (int i = 0; i < LANES; i++) reqAddr[i*ADDR_W +: ADDR_W] = laneAddr[i];
    reqActive = laneAct;
  endtask

  // handshake: present at a negedge, accepted at the following posedge
  task automatic sendRequest();
    driveInputs();
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    reqValid = 1'b1;
    @(posedge clk);
    #1 reqValid = 1'b0;
  endtask

  // observe from the negedge after acceptance until the completion strobe
  task automatic collect();
    int cyc;
    obsCount = 0; obsDone = 1'b0; obsGap = 0; obsFirstCycle = -1; obsDoneCycle = -1;
    cyc = 0;
    while (!obsDone && cyc < 200) begin
      @(negedge clk);
      cyc++;
      if (txnValid) begin
        if (obsFirstCycle < 0) obsFirstCycle = cyc;
        if (obsCount < 64) begin
          obsLine[obsCount] = txnLine;
          obsMask[obsCount] = txnMask;
        end
        obsCount++;
      end else if (!doneValid && obsCount > 0) begin
        obsGap++;
      end
      if (doneValid) begin
        obsDone = 1'b1;
        obsDoneCycle = cyc;
        obsSectors = int'(doneSectors);
        obsMoved   = int'(doneMoved);
        obsUseful  = int'(doneUseful);
      end
    end
    check(obsDone, "R4", "completion strobe seen", obsDone, 1);
  endtask

  task automatic compareAll(input string tag);
    check(obsCount == expCount, "R4", {tag, " transaction count"}, obsCount, expCount);
    for (int t = 0; t < expCount && t < obsCount; t++) begin
      check(obsLine[t] == expLine[t], "R5", {tag, " line order"}, obsLine[t], expLine[t]);
      check(obsMask[t] == expMask[t], "R3", {tag, " sector mask"}, obsMask[t], expMask[t]);
    end
    if (expCount > 0) begin
      check(obsFirstCycle == 1, "R4", {tag, " first txn cycle"}, obsFirstCycle, 1);
      check(obsDoneCycle == expCount + 1, "R4", {tag, " done cycle"}, obsDoneCycle, expCount + 1);
    end
    check(obsGap == 0, "R4", {tag, " gaps between txns"}, obsGap, 0);
    check(obsSectors == expSectors, "R8", {tag, " sectors"}, obsSectors, expSectors);
    check(obsMoved == 32 * expSectors, "R8", {tag, " moved bytes"}, obsMoved, 32 * expSectors);
    check(obsUseful == expUseful, "R9", {tag, " useful bytes"}, obsUseful, expUseful);
  endtask

  task automatic runAndCompare(input string tag);
    buildExpected();
    sendRequest();
    collect();
    compareAll(tag);
  endtask

  task automatic testReset();
    check(reqReady == 1'b1, "R1", "ready after reset", reqReady, 1);
    check(txnValid == 1'b0, "R1", "txnValid after reset", txnValid, 0);
    check(doneValid == 1'b0, "R1", "doneValid after reset", doneValid, 0);
  endtask

  task automatic testContiguous();
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0001_2300 + 32'(4 * i);
    laneAct = '1;
    runAndCompare("contiguous");
    check(obsCount == 1 && obsMask[0] == 4'b1111, "R10", "single full txn", obsMask[0], 15);
    check(obsMoved == 128 && obsUseful == 128, "R10", "128 moved/useful", obsMoved, 128);
  endtask

  task automatic testStrided();
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0040_0000 + 32'(4096 * i) + 32'(32 * (i % 4));
    laneAct = '1;
    runAndCompare("strided");
    check(obsCount == 32, "R11", "32 txns", obsCount, 32);
    check(obsMoved == 1024, "R11", "1024 moved", obsMoved, 1024);
    check(obsUseful == 128, "R11", "128 useful", obsUseful, 128);
  endtask

  task automatic testReverseOrder();
    // lane i -> line (7 - i%8), sector i/8: lines first touched in descending order
    for (int i = 0; i < LANES; i++)
      laneAddr[i] = 32'h0000_8000 + 32'(128 * (7 - i % 8)) + 32'(32 * (i / 8)) + 32'(4 * (i % 3));
    laneAct = '1;
    runAndCompare("reverse");
    check(obsLine[0] == LINE_W'(32'h0000_8000 >> 7) + LINE_W'(7), "R5", "first line is lane0's",
          obsLine[0], (32'h8000 >> 7) + 7);
  endtask

  task automatic testInactive();
    for (int i = 0; i < LANES; i++)
      laneAddr[i] = (i < 8) ? 32'h0000_1000 + 32'(4 * i) : 32'h0999_0000 + 32'(160 * i);
    laneAct = 32'h0000_00FF;
    runAndCompare("inactive");
    check(obsCount == 1 && obsMask[0] == 4'b0001, "R6", "only active lanes counted", obsMask[0], 1);
    check(obsUseful == 32, "R6", "useful from active lanes", obsUseful, 32);
  endtask

  task automatic testEmpty();
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'(i * 512);
    laneAct = '0;
    buildExpected();
    sendRequest();
    collect();
    check(obsCount == 0, "R7", "no txn for empty", obsCount, 0);
    check(obsDoneCycle == 1, "R7", "done right after accept", obsDoneCycle, 1);
    check(obsSectors == 0 && obsUseful == 0, "R7", "zero counts", obsSectors, 0);
  endtask

  task automatic testDuplicates();
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0000_2044;
    laneAct = '1;
    runAndCompare("same word");
    check(obsUseful == 4 && obsMoved == 32, "R9", "one word counted once", obsUseful, 4);
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0000_3000 + 32'(4 * (i / 2));
    runAndCompare("pairs");
    check(obsUseful == 64, "R9", "pairs count 16 words", obsUseful, 64);
  endtask

  task automatic testBusyIgnore();
    // request A: strided, long; then new data offered while busy
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0100_0000 + 32'(128 * i) + 32'(32 * ((i + 1) % 4));
    laneAct = '1;
    buildExpected();
    sendRequest();
    @(negedge clk);
    check(reqReady == 1'b0, "R2", "not ready while busy", reqReady, 0);
    for (int i = 0; i < LANES; i++) laneAddr[i] = 32'h0200_0000 + 32'(4 * i);
    laneAct = 32'h0F0F_0F0F;
    driveInputs();
    reqValid = 1'b1;
    // one transaction already seen at the negedge above; collect the rest
    begin
      int seenBefore;
      seenBefore = 1;
      obsLine[0] = txnLine;
      obsMask[0] = txnMask;
      collect();
      for (int t = obsCount - 1; t >= 0; t--) begin
        obsLine[t + 1] = obsLine[t];
        obsMask[t + 1] = obsMask[t];
      end
      obsLine[0] = LINE_W'(32'h0100_0000 >> 7);
      obsMask[0] = 4'b0010;
      obsCount = obsCount + seenBefore;
      check(obsCount == expCount, "R2", "busy: count of first request", obsCount, expCount);
      for (int t = 1; t < expCount && t < obsCount; t++)
        check(obsLine[t] == expLine[t] && obsMask[t] == expMask[t], "R2",
              "busy: txn of first request", obsLine[t], expLine[t]);
      check(obsSectors == expSectors && obsUseful == expUseful, "R2",
            "busy: counts of first request", obsUseful, expUseful);
    end
    // B accepted in the first ready cycle
    @(negedge clk);
    check(reqReady == 1'b1, "R2", "ready after done", reqReady, 1);
    buildExpected();
    @(posedge clk);
    #1 reqValid = 1'b0;
    collect();
    compareAll("second");
  endtask

  task automatic testRandom();
    logic [31:0] seed;
    seed = 32'h1234_5678;
    for (int n = 0; n < 12; n++) begin
      for (int i = 0; i < LANES; i++) begin
        seed = seed * 32'd1664525 + 32'd1013904223;
        laneAddr[i] = 32'h0030_0000 + {22'd0, seed[19:12], 2'b00};
        laneAct[i]  = (seed[27:25] != 3'd0);
      end
      runAndCompare("random");
    end
  endtask

  initial begin
    #2_000_000;
    check(1'b0, "R4", "watchdog expired", 0, 1);
    finishRun();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    testReset();
    testContiguous();
    testStrided();
    testReverseOrder();
    testInactive();
    testEmpty();
    testDuplicates();
    testBusyIgnore();
    testRandom();
    repeat (3) @(negedge clk);
    finishRun();
  end

endmodule